// File: doc/BRIEF.md
# Sticky Alarm Status Register

This block collects the health alarms of a two-channel data-converter digital back end into one software-visible byte. Each alarm bit is sticky: once its hardware condition is seen on a rising clock edge the bit goes high and holds there until software writes a one to that bit position. The conditions come from outside as per-cycle levels or pulses: lane FIFO errors, PLL lock, link state and start-up, realignment events, SYSREF clock realignment and NCO synchronization. Two conditions are computed here, from live cross-channel comparisons: the channel A and channel B NCO phase accumulators, and the two channels' clock-divider states.

A second sticky register holds one bit per lane, so that software can see which lane raised the FIFO alarm. Both registers sit behind a simple write strobe and address, and the read data is a combinational view of the selected register. After an asynchronous reset or a synchronous soft reset every alarm bit reads one. While the converter enable is low, only the clock-divider alarm carries meaning. Software is expected to clear the register after raising the enable.

Top module: `alarm_status_reg`

## Requirements
- R1: After `rstN` is asserted, or in the cycle after `softRst` is high at a clock edge, status bits 5:0 and every lane bit read one. Soft reset takes priority over every set and clear.
- R2: Writing with `regWrEn` high clears each bit whose write-data bit is one, and leaves the bits written with zero unchanged. A bit that is set holds until it is cleared. If a hardware set and a software clear hit the same bit in the same cycle, the bit stays one.
- R3: `regAddr`=0 selects the status register, whose bits 7:6 always read zero whatever was written. `regAddr`=1 selects the lane register, whose bit i belongs to lane i.
- R4: Status bit 5 (FIFO) sets when some lane has both `laneActive` and `laneFifoErr` high. An error on an inactive lane has no effect.
- R5: Lane register bit i sets when lane i is active and reports an error. It is cleared by writing one to it at `regAddr`=1.
- R6: Status bit 4 (PLL) sets in every cycle in which `pllLocked` is low.
- R7: With `mode64b`=0, status bit 3 (link) sets when `linkEn` is high and `linkInData` is low.
- R8: With `mode64b`=1, status bit 3 sets on `linkStart` or `realignEvt`. In this mode the `linkEn`/`linkInData` state has no effect.
- R9: Status bit 2 (realigned) sets when `sysrefRealign` is high.
- R10: Status bit 1 (NCO) sets when `convEn` is low, when `ncoSync` is high, or when any channel A accumulator slice differs from the same slice of channel B.
- R11: Status bit 0 (clock) sets when `clkDivA` differs from `clkDivB`, and this holds regardless of `convEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous soft reset, sets all alarms |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 status, 1 lane |
| regWrData | input | 8 | Write-one-to-clear data |
| regRdData | output | 8 | Read data of the selected register |
| laneActive | input | NUM_LANES | Lane is in use |
| laneFifoErr | input | NUM_LANES | Lane FIFO overflow or underflow this cycle |
| pllLocked | input | 1 | PLL lock indication |
| mode64b | input | 1 | 1 = 64b/66b link mode, 0 = 8b/10b |
| linkEn | input | 1 | Link enabled |
| linkInData | input | 1 | Link in its data-transmission state |
| linkStart | input | 1 | Link start-up pulse |
| realignEvt | input | 1 | FIFO or serializer realignment pulse |
| sysrefRealign | input | 1 | SYSREF realigned the internal clocks |
| convEn | input | 1 | Converter enable |
| ncoSync | input | 1 | NCO synchronization event |
| ncoAccA | input | NUM_NCO*ACC_W | Channel A phase accumulators |
| ncoAccB | input | NUM_NCO*ACC_W | Channel B phase accumulators |
| clkDivA | input | DIV_W | Channel A clock-divider state |
| clkDivB | input | DIV_W | Channel B clock-divider state |

## Verification
On every cycle the assertions check four things: the PLL and clock-divider alarms rise the cycle after their condition, a set bit holds until a clear addressed to it, a write-one clears the PLL bit when no unlock competes, and soft reset forces all ones. The reserved bits reading zero is also checked every cycle. Only the bench scenarios can show the rest. They cover the mode-dependent link alarm, inactive lanes being ignored, the per-slice NCO comparison, set winning over a clear in the same cycle, and the lane register's own clear. A random run checks every bit against a model while the enable toggles.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int REG_W = 8;
  localparam int ALM_N = 6;
  localparam int BIT_CLK  = 0;
  localparam int BIT_NCO  = 1;
  localparam int BIT_RALN = 2;
  localparam int BIT_LINK = 3;
  localparam int BIT_PLL  = 4;
  localparam int BIT_FIFO = 5;

  typedef struct packed {
    logic             softRst;
    logic             clrMain;
    logic             clrLane;
    logic             rdLane;
    logic [REG_W-1:0] clrData;
  } almStrobe_t;
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
(
  input  logic             softRst,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [REG_W-1:0] regWrData,
  output almStrobe_t       strb
);
  always_comb begin
    strb.softRst = softRst;
    strb.clrMain = regWrEn && !regAddr;
    strb.clrLane = regWrEn && regAddr;
    strb.rdLane  = regAddr;
    strb.clrData = regWrData;
  end
endmodule

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int NUM_NCO   = 2,
  parameter int ACC_W     = 16,
  parameter int DIV_W     = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  almStrobe_t               strb,
  input  logic [NUM_LANES-1:0]     laneActive,
  input  logic [NUM_LANES-1:0]     laneFifoErr,
  input  logic                     pllLocked,
  input  logic                     mode64b,
  input  logic                     linkEn,
  input  logic                     linkInData,
  input  logic                     linkStart,
  input  logic                     realignEvt,
  input  logic                     sysrefRealign,
  input  logic                     convEn,
  input  logic                     ncoSync,
  input  logic [NUM_NCO*ACC_W-1:0] ncoAccA,
  input  logic [NUM_NCO*ACC_W-1:0] ncoAccB,
  input  logic [DIV_W-1:0]         clkDivA,
  input  logic [DIV_W-1:0]         clkDivB,
  output logic [ALM_N-1:0]         mainAlm,
  output logic [NUM_LANES-1:0]     laneAlm,
  output logic [REG_W-1:0]         rdData
);
  localparam int PAD_W = REG_W - NUM_LANES;
  localparam int RES_W = REG_W - ALM_N;

  logic [NUM_NCO-1:0]   ncoMis;
  logic [NUM_LANES-1:0] laneHit;
  logic [ALM_N-1:0]     setVec;
  logic                 linkCond;
  logic                 unusedResv;

  for (genvar n = 0; n < NUM_NCO; n++) begin : g_ncoCmp
    assign ncoMis[n] = ncoAccA[n*ACC_W +: ACC_W] != ncoAccB[n*ACC_W +: ACC_W];
  end

  assign laneHit    = laneActive & laneFifoErr;
  assign linkCond   = mode64b ? (linkStart || realignEvt) : (linkEn && !linkInData);
  assign unusedResv = ^strb.clrData[REG_W-1:ALM_N];

  always_comb begin
    setVec           = '0;
    setVec[BIT_FIFO] = |laneHit;
    setVec[BIT_PLL]  = !pllLocked;
    setVec[BIT_LINK] = linkCond;
    setVec[BIT_RALN] = sysrefRealign;
    setVec[BIT_NCO]  = !convEn || ncoSync || (|ncoMis);
    setVec[BIT_CLK]  = clkDivA != clkDivB;
  end

  for (genvar b = 0; b < ALM_N; b++) begin : g_mainCell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              mainAlm[b] <= 1'b1;
      else if (strb.softRst)  mainAlm[b] <= 1'b1;
      else if (setVec[b])     mainAlm[b] <= 1'b1;
      else if (strb.clrMain && strb.clrData[b]) mainAlm[b] <= 1'b0;
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_laneCell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              laneAlm[l] <= 1'b1;
      else if (strb.softRst)  laneAlm[l] <= 1'b1;
      else if (laneHit[l])    laneAlm[l] <= 1'b1;
      else if (strb.clrLane && strb.clrData[l]) laneAlm[l] <= 1'b0;
    end
  end

  if (PAD_W > 0) begin : g_padLane
    assign rdData = strb.rdLane ? {{PAD_W{1'b0}}, laneAlm} : {{RES_W{1'b0}}, mainAlm};
  end else begin : g_fullLane
    assign rdData = strb.rdLane ? laneAlm : {{RES_W{1'b0}}, mainAlm};
  end
endmodule

// File: rtl/alarm_status_reg.sv
module alarm_status_reg
  import alarm_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int NUM_NCO   = 2,
  parameter int ACC_W     = 16,
  parameter int DIV_W     = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     softRst,
  input  logic                     regWrEn,
  input  logic                     regAddr,
  input  logic [REG_W-1:0]         regWrData,
  output logic [REG_W-1:0]         regRdData,
  input  logic [NUM_LANES-1:0]     laneActive,
  input  logic [NUM_LANES-1:0]     laneFifoErr,
  input  logic                     pllLocked,
  input  logic                     mode64b,
  input  logic                     linkEn,
  input  logic                     linkInData,
  input  logic                     linkStart,
  input  logic                     realignEvt,
  input  logic                     sysrefRealign,
  input  logic                     convEn,
  input  logic                     ncoSync,
  input  logic [NUM_NCO*ACC_W-1:0] ncoAccA,
  input  logic [NUM_NCO*ACC_W-1:0] ncoAccB,
  input  logic [DIV_W-1:0]         clkDivA,
  input  logic [DIV_W-1:0]         clkDivB
);
  almStrobe_t           strb;
  logic [ALM_N-1:0]     mainAlm;
  logic [NUM_LANES-1:0] laneAlm;

  alarm_ctrl ctrl_i (
    .softRst(softRst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb)
  );

  alarm_datapath #(
    .NUM_LANES(NUM_LANES), .NUM_NCO(NUM_NCO), .ACC_W(ACC_W), .DIV_W(DIV_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .laneActive(laneActive), .laneFifoErr(laneFifoErr),
    .pllLocked(pllLocked), .mode64b(mode64b), .linkEn(linkEn),
    .linkInData(linkInData), .linkStart(linkStart), .realignEvt(realignEvt),
    .sysrefRealign(sysrefRealign), .convEn(convEn), .ncoSync(ncoSync),
    .ncoAccA(ncoAccA), .ncoAccB(ncoAccB), .clkDivA(clkDivA), .clkDivB(clkDivB),
    .mainAlm(mainAlm), .laneAlm(laneAlm), .rdData(regRdData)
  );
endmodule

// File: rtl/alarm_status_chk.sv
module alarm_status_chk
  import alarm_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             softRst,
  input logic             regWrEn,
  input logic             regAddr,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             pllLocked,
  input logic [DIV_W-1:0] clkDivA,
  input logic [DIV_W-1:0] clkDivB,
  input logic [ALM_N-1:0] mainAlm
);
  assert_soft_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (mainAlm == {ALM_N{1'b1}}));

  for (genvar b = 0; b < ALM_N; b++) begin : g_hold
    assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      (mainAlm[b] && !(regWrEn && !regAddr && regWrData[b])) |=> mainAlm[b]);
  end

  assert_clear_pll_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regAddr && regWrData[BIT_PLL] && pllLocked && !softRst) |=> !mainAlm[BIT_PLL]);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> (regRdData[REG_W-1:ALM_N] == '0));

  assert_pll_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pllLocked |=> mainAlm[BIT_PLL]);

  assert_clk_set_R11: assert property (@(posedge clk) disable iff (!rstN)
    (clkDivA != clkDivB) |=> mainAlm[BIT_CLK]);
endmodule

bind alarm_status_reg alarm_status_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rstN(rstN), .softRst(softRst), .regWrEn(regWrEn),
  .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
  .pllLocked(pllLocked), .clkDivA(clkDivA), .clkDivB(clkDivB),
  .mainAlm(mainAlm)
);

// File: tb/alarm_status_reg_tb_top.sv
module alarm_status_reg_tb_top;
  localparam int NL = 8;
  localparam int NN = 2;
  localparam int AW = 16;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 0, regWrEn = 0, regAddr = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic [NL-1:0] laneActive = 0, laneFifoErr = 0;
  logic pllLocked = 1, mode64b = 0, linkEn = 0, linkInData = 1;
  logic linkStart = 0, realignEvt = 0, sysrefRealign = 0, convEn = 0, ncoSync = 0;
  logic [NN*AW-1:0] ncoAccA = 0, ncoAccB = 0;
  logic [DW-1:0] clkDivA = 0, clkDivB = 0;

  int total = 0, bad = 0;
  bit done = 0;
  bit fullValid = 0;
  logic [5:0] expMain;
  logic [NL-1:0] expLane;

  always #10 clk = ~clk;

  alarm_status_reg #(.NUM_LANES(NL), .NUM_NCO(NN), .ACC_W(AW), .DIV_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .laneActive(laneActive),
    .laneFifoErr(laneFifoErr), .pllLocked(pllLocked), .mode64b(mode64b),
    .linkEn(linkEn), .linkInData(linkInData), .linkStart(linkStart),
    .realignEvt(realignEvt), .sysrefRealign(sysrefRealign), .convEn(convEn),
    .ncoSync(ncoSync), .ncoAccA(ncoAccA), .ncoAccB(ncoAccB),
    .clkDivA(clkDivA), .clkDivB(clkDivB)
  );

  function automatic logic [5:0] setBits();
    logic [5:0] s;
    s[5] = |(laneActive & laneFifoErr);
    s[4] = !pllLocked;
    s[3] = mode64b ? (linkStart | realignEvt) : (linkEn & !linkInData);
    s[2] = sysrefRealign;
    s[1] = !convEn | ncoSync | (ncoAccA[AW-1:0] != ncoAccB[AW-1:0]) |
           (ncoAccA[2*AW-1:AW] != ncoAccB[2*AW-1:AW]);
    s[0] = clkDivA != clkDivB;
    return s;
  endfunction

  task automatic tick();
    logic [5:0] clrM;
    logic [NL-1:0] clrL;
    clrM = (regWrEn && !regAddr) ? regWrData[5:0] : 6'h0;
    clrL = (regWrEn && regAddr) ? regWrData[NL-1:0] : '0;
    if (softRst) begin
      expMain = 6'h3F;
      expLane = '1;
    end else begin
      expMain = (expMain & ~clrM) | setBits();
      expLane = (expLane & ~clrL) | (laneActive & laneFifoErr);
    end
    if (!convEn || softRst) fullValid = 0;
    else if (clrM[5:1] == 5'h1F) fullValid = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic sel);
    logic [7:0] expV, mask;
    regAddr = sel;
    #1;
    expV = sel ? 8'(expLane) : {2'b00, expMain};
    mask = (sel || fullValid) ? 8'hFF : 8'hC1;
    total++;
    if ((regRdData & mask) !== (expV & mask)) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h mask=%02h",
               tag, sel, regRdData, expV, mask);
    end
  endtask

  task automatic quiet();
    softRst = 0; regWrEn = 0; laneFifoErr = 0; pllLocked = 1;
    linkStart = 0; realignEvt = 0; sysrefRealign = 0; ncoSync = 0;
    ncoAccB = ncoAccA; clkDivB = clkDivA;
    linkInData = 1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    tick();
    regWrEn = 0;
  endtask

  task automatic clearAll();
    wr(0, 8'hFF);
    wr(1, 8'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    expMain = 6'h3F; expLane = '1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset value, all ones
    check("R1 reset status", 0);
    check("R1 reset lane", 1);

    convEn = 1; laneActive = 8'h0F; quiet();
    tick();
    clearAll();
    check("R2 clear all status", 0);
    check("R2 clear all lane", 1);

    // R3: reserved bits stay zero after writes
    wr(0, 8'hC0);
    check("R3 reserved read zero", 0);

    // R6 then R2: zero-write keeps, set wins over clear
    pllLocked = 0; tick(); quiet();
    check("R6 pll unlock", 0);
    wr(0, 8'h00);
    check("R2 zero write keeps", 0);
    pllLocked = 0; wr(0, 8'h10); quiet();
    check("R2 set wins over clear", 0);
    wr(0, 8'h10);
    check("R2 clear after set", 0);

    // R4 / R5 lanes
    laneFifoErr = 8'h80; tick(); quiet();
    check("R4 inactive lane ignored", 0);
    check("R5 inactive lane record", 1);
    laneFifoErr = 8'h08; tick(); quiet();
    check("R4 active lane fifo", 0);
    check("R5 lane 3 record", 1);
    wr(1, 8'h08);
    check("R5 lane clear", 1);
    wr(0, 8'h20);

    // R7 8b/10b link
    linkEn = 1; linkInData = 0; tick(); quiet();
    check("R7 link not in data", 0);
    wr(0, 8'h08);
    linkEn = 0; linkInData = 0; tick(); quiet();
    check("R7 link disabled no alarm", 0);

    // R8 64b/66b link
    mode64b = 1; linkEn = 1; linkInData = 0; tick(); quiet();
    check("R8 state ignored in 64b", 0);
    linkStart = 1; tick(); quiet();
    check("R8 link start", 0);
    wr(0, 8'h08);
    realignEvt = 1; tick(); quiet();
    check("R8 realign event", 0);
    wr(0, 8'h08);
    mode64b = 0; linkEn = 0;

    // R9
    sysrefRealign = 1; tick(); quiet();
    check("R9 sysref realign", 0);
    wr(0, 8'h04);

    // R10
    ncoSync = 1; tick(); quiet();
    check("R10 nco sync", 0);
    wr(0, 8'h02);
    ncoAccB[AW +: AW] = ncoAccA[AW +: AW] ^ 16'h0100; tick(); quiet();
    check("R10 second accumulator mismatch", 0);
    wr(0, 8'h02);
    check("R10 nco quiet after clear", 0);

    // R11 with enable low
    convEn = 0; tick();
    clkDivB = clkDivA + 1'b1; tick(); quiet();
    check("R11 clock alarm enable low", 0);
    wr(0, 8'h01);
    check("R11 clock cleared enable low", 0);
    convEn = 1; tick();
    wr(0, 8'h3F);
    check("R10 nco clear after enable", 0);

    // R1 soft reset
    softRst = 1; tick(); quiet();
    check("R1 soft reset status", 0);
    check("R1 soft reset lane", 1);
    clearAll();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      quiet();
      laneActive  = 8'($urandom);
      laneFifoErr = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
      pllLocked   = ($urandom % 12 != 0);
      mode64b     = ($urandom % 64 == 0) ? ~mode64b : mode64b;
      linkEn      = $urandom % 2;
      linkInData  = ($urandom % 8 != 0);
      linkStart   = ($urandom % 20 == 0);
      realignEvt  = ($urandom % 20 == 0);
      sysrefRealign = ($urandom % 16 == 0);
      ncoSync     = ($urandom % 20 == 0);
      ncoAccA     = {$urandom, $urandom} & {(NN*AW){1'b1}};
      ncoAccB     = ($urandom % 12 == 0) ? ncoAccA ^ (32'h1 << ($urandom % 32)) : ncoAccA;
      clkDivA     = DW'($urandom);
      clkDivB     = ($urandom % 12 == 0) ? DW'($urandom) : clkDivA;
      convEn      = ($urandom % 100 == 0) ? ~convEn : convEn;
      softRst     = ($urandom % 400 == 0);
      regAddr     = $urandom % 2;
      regWrData   = 8'($urandom);
      regWrEn     = ($urandom % 3 == 0);
      tick();
      regWrEn = 0;
      check("R2 random model", 1'($urandom % 2));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule